// File: doc/BRIEF.md
# Vector widening shift-left unit

This block runs the widening logical left shift on a group of packed vector elements. Each source element is SEW bits wide. It is zero-extended to 2*SEW bits, shifted left and written into a destination lane twice as wide. The shift amount comes from one of three places: a per-element vector of amounts, one scalar value shared by all lanes, or a 5-bit immediate carried in the instruction word. In every case, only the low log2(2*SEW) bits of the amount are used.

The unit decodes the 32-bit instruction word itself, applies the per-element mask and registers the whole destination group. A valid/ready handshake frames each operation. The result appears one cycle after the request is accepted. It holds while the consumer stalls. A word that is not this instruction, or that asks for 64-bit elements, comes back flagged illegal. The write enable is then low and the old destination is returned unchanged.

Top module: `vwsll_unit`

## Requirements
- R1: A word is legal only when bits [31:26] = 110101, bits [6:0] = 1010111 and bits [14:12] are 000, 100 or 011. Any other word is flagged illegal, with `wr_en` low and `result` equal to `old_dst`.
- R2: With bits [14:12] = 000, destination element i is zero-extended source element i shifted left by element i of `vs1_data` ANDed with 2*SEW-1.
- R3: With bits [14:12] = 100, every element shifts by the low SEW bits of `scalar_op` ANDed with 2*SEW-1.
- R4: With bits [14:12] = 011, every element shifts by bits [19:15] zero-extended and ANDed with 2*SEW-1. For example, immediate 20 at SEW=8 shifts by 4.
- R5: Bits shifted past bit 2*SEW-1 are dropped and the vacated low bits are zero. For example, 0xFF shifted by 15 at SEW=8 gives 0x8000.
- R6: When bit 25 is 0, element i is written only if `elem_mask[i]` is 1; otherwise its old value from `old_dst` is returned. When bit 25 is 1, every element is written.
- R7: `sew_sel` encodes 00 = 8, 01 = 16 and 10 = 32 bits. Value 11 (64 bits) is flagged illegal and writes nothing.
- R8: `in_ready` equals `!out_valid || out_ready`. An accepted request raises `out_valid` at the next clock edge. `out_valid` and `result` hold while `out_ready` is low.
- R9: Under reset, `out_valid`, `wr_en` and `illegal` are 0, `result` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request |
| instr | input | 32 | Instruction word |
| sew_sel | input | 2 | Source element width select |
| vs2_data | input | VLEN | Packed source elements |
| vs1_data | input | VLEN | Packed per-element shift amounts |
| scalar_op | input | 32 | Scalar shift amount |
| old_dst | input | 2*VLEN | Previous destination contents |
| elem_mask | input | VLEN/8 | Per-element mask, bit i for element i |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| wr_en | output | 1 | Result should be written |
| illegal | output | 1 | Request was not a legal operation |
| result | output | 2*VLEN | Packed widened destination elements |

## Verification
Every output (`result`, `wr_en`, `illegal`, `out_valid`) becomes due at the first clock edge after the edge that accepts the request. The bench drives inputs on the falling edge and reads the outputs on the next falling edge, half a period after they update. `in_ready` is combinational, so it is read in the same low phase as the inputs that set it. The stall test holds `out_ready` low for extra cycles and reads `result` again on each falling edge to confirm it has not moved.

// File: rtl/vwsll_pkg.sv
package vwsll_pkg;

    typedef enum logic [1:0] {
        SEW_E8  = 2'b00,
        SEW_E16 = 2'b01,
        SEW_E32 = 2'b10,
        SEW_E64 = 2'b11
    } sew_e;

    typedef enum logic [1:0] {
        OPF_VV   = 2'd0,
        OPF_VX   = 2'd1,
        OPF_VI   = 2'd2,
        OPF_NONE = 2'd3
    } opform_e;

    localparam logic [5:0] F6_WSLL  = 6'b110101;
    localparam logic [6:0] OP_VEC   = 7'b1010111;
    localparam logic [2:0] F3_VV    = 3'b000;
    localparam logic [2:0] F3_VX    = 3'b100;
    localparam logic [2:0] F3_VI    = 3'b011;

    typedef struct packed {
        logic    legal;
        opform_e form;
        logic    mask_en;
        logic [4:0] imm;
    } dec_t;

    function automatic dec_t decode_word(input logic [31:0] w);
        dec_t d;
        d.legal   = 1'b0;
        d.form    = OPF_NONE;
        d.mask_en = ~w[25];
        d.imm     = w[19:15];
        if (w[31:26] == F6_WSLL && w[6:0] == OP_VEC) begin
            unique case (w[14:12])
                F3_VV:   begin d.form = OPF_VV; d.legal = 1'b1; end
                F3_VX:   begin d.form = OPF_VX; d.legal = 1'b1; end
                F3_VI:   begin d.form = OPF_VI; d.legal = 1'b1; end
                default: begin d.form = OPF_NONE; d.legal = 1'b0; end
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/vwsll_decode.sv
module vwsll_decode
    import vwsll_pkg::*;
(
    input  logic [31:0] instr,
    input  logic [1:0]  sew_sel,
    output dec_t        dec,
    output logic        bad
);
    always_comb begin
        dec = decode_word(instr);
        bad = ~dec.legal | (sew_e'(sew_sel) == SEW_E64);
    end
endmodule

// File: rtl/vwsll_lane.sv
module vwsll_lane
    import vwsll_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]   src,
    input  logic [W-1:0]   vec_amt,
    input  logic [W-1:0]   scalar_amt,
    input  logic [4:0]     imm,
    input  opform_e        form,
    input  logic           active,
    input  logic [2*W-1:0] old,
    output logic [2*W-1:0] dst
);
    localparam int SHW = $clog2(2 * W);

    logic [W-1:0]   amt;
    logic [2*W-1:0] wide;

    always_comb begin
        unique case (form)
            OPF_VV:  amt = vec_amt;
            OPF_VX:  amt = scalar_amt;
            default: amt = {{(W-5){1'b0}}, imm};
        endcase
        wide = {{W{1'b0}}, src};
        dst  = active ? (wide << amt[SHW-1:0]) : old;
    end
endmodule

// File: rtl/vwsll_group.sv
module vwsll_group
    import vwsll_pkg::*;
#(
    parameter int VLEN = 64,
    parameter int W    = 8
) (
    input  logic [VLEN-1:0]   src_v,
    input  logic [VLEN-1:0]   amt_v,
    input  logic [31:0]       scalar_op,
    input  dec_t              dec,
    input  logic [VLEN/8-1:0] elem_mask,
    input  logic [2*VLEN-1:0] old_v,
    output logic [2*VLEN-1:0] dst_v
);
    localparam int NE = VLEN / W;

    for (genvar i = 0; i < NE; i++) begin : g_lane
        logic act;
        assign act = ~dec.mask_en | elem_mask[i];
        vwsll_lane #(.W(W)) u_lane (
            .src        (src_v[i*W +: W]),
            .vec_amt    (amt_v[i*W +: W]),
            .scalar_amt (scalar_op[W-1:0]),
            .imm        (dec.imm),
            .form       (dec.form),
            .active     (act),
            .old        (old_v[i*2*W +: 2*W]),
            .dst        (dst_v[i*2*W +: 2*W])
        );
    end
endmodule

// File: rtl/vwsll_unit.sv
module vwsll_unit
    import vwsll_pkg::*;
#(
    parameter int VLEN = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [31:0]         instr,
    input  logic [1:0]          sew_sel,
    input  logic [VLEN-1:0]     vs2_data,
    input  logic [VLEN-1:0]     vs1_data,
    input  logic [31:0]         scalar_op,
    input  logic [2*VLEN-1:0]   old_dst,
    input  logic [VLEN/8-1:0]   elem_mask,
    output logic                out_valid,
    input  logic                out_ready,
    output logic                wr_en,
    output logic                illegal,
    output logic [2*VLEN-1:0]   result
);
    localparam int NSEW = 3;

    dec_t               dec;
    logic               bad;
    logic [2*VLEN-1:0]  grp_res [NSEW];
    logic [2*VLEN-1:0]  sel_res;
    logic               accept;

    vwsll_decode u_dec (
        .instr   (instr),
        .sew_sel (sew_sel),
        .dec     (dec),
        .bad     (bad)
    );

    for (genvar g = 0; g < NSEW; g++) begin : g_sew
        vwsll_group #(.VLEN(VLEN), .W(8 << g)) u_grp (
            .src_v     (vs2_data),
            .amt_v     (vs1_data),
            .scalar_op (scalar_op),
            .dec       (dec),
            .elem_mask (elem_mask),
            .old_v     (old_dst),
            .dst_v     (grp_res[g])
        );
    end

    always_comb begin
        unique case (sew_e'(sew_sel))
            SEW_E8:  sel_res = grp_res[0];
            SEW_E16: sel_res = grp_res[1];
            SEW_E32: sel_res = grp_res[2];
            default: sel_res = old_dst;
        endcase
    end

    assign in_ready = ~out_valid | out_ready;
    assign accept   = in_valid & in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            wr_en     <= 1'b0;
            illegal   <= 1'b0;
            result    <= '0;
        end else if (accept) begin
            out_valid <= 1'b1;
            wr_en     <= ~bad;
            illegal   <= bad;
            result    <= bad ? old_dst : sel_res;
        end else if (out_ready) begin
            out_valid <= 1'b0;
            wr_en     <= 1'b0;
            illegal   <= 1'b0;
        end
    end
endmodule

// File: rtl/vwsll_unit_chk.sv
module vwsll_unit_chk #(
    parameter int VLEN = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic              wr_en,
    input logic              illegal,
    input logic [2*VLEN-1:0] result
);
    AST_ACCEPT_GIVES_VALID: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid); // R8
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(result)); // R8
    AST_ILLEGAL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
        out_valid && illegal |-> !wr_en); // R1
    AST_LEGAL_WRITES: assert property (@(posedge clk) disable iff (rst)
        out_valid && !illegal |-> wr_en); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !wr_en && !illegal); // R9
endmodule

bind vwsll_unit vwsll_unit_chk #(.VLEN(VLEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .wr_en     (wr_en),
    .illegal   (illegal),
    .result    (result)
);

// File: tb/vwsll_unit_bench.sv
module vwsll_unit_bench;
    localparam int VLEN = 64;

    typedef struct packed {
        logic [31:0]  ins;
        logic [1:0]   sew;
        logic [63:0]  src;
        logic [63:0]  amt;
        logic [31:0]  sc;
        logic [127:0] old;
        logic [7:0]   msk;
    } vec_t;

    function automatic logic [31:0] mk(input logic [5:0] f6, input logic vm,
                                       input logic [4:0] f15, input logic [2:0] f3,
                                       input logic [6:0] op);
        return {f6, vm, 5'd2, f15, f3, 5'd4, op};
    endfunction

    localparam logic [127:0] OLDP = 128'hA5A5_5A5A_C3C3_3C3C_0F0F_F0F0_1234_5678;

    localparam vec_t TBL [9] = '{
        '{mk(6'b110101,1'b1,5'd1, 3'b000,7'b1010111), 2'b00, 64'h0102_0408_1020_40FF, 64'h0013_0F07_0302_0100, 32'h0, OLDP, 8'h00},
        '{mk(6'b110101,1'b1,5'd1, 3'b100,7'b1010111), 2'b01, 64'hFFFF_8001_1234_0001, 64'h0, 32'h0001_0025, OLDP, 8'h00},
        '{mk(6'b110101,1'b1,5'd31,3'b011,7'b1010111), 2'b10, 64'hFFFF_FFFF_0000_0003, 64'h0, 32'h0, OLDP, 8'h00},
        '{mk(6'b110101,1'b1,5'd20,3'b011,7'b1010111), 2'b00, 64'h8040_2010_0804_0201, 64'h0, 32'h0, OLDP, 8'h00},
        '{mk(6'b110101,1'b0,5'd1, 3'b000,7'b1010111), 2'b10, 64'h0000_0011_0000_0022, 64'h0000_003F_0000_0004, 32'h0, OLDP, 8'h01},
        '{mk(6'b110101,1'b0,5'd1, 3'b100,7'b1010111), 2'b00, 64'hFFEE_DDCC_BBAA_9988, 64'h0, 32'h0000_0103, OLDP, 8'hA5},
        '{mk(6'b110101,1'b1,5'd1, 3'b001,7'b1010111), 2'b00, 64'h1111_1111_1111_1111, 64'h0, 32'h0, OLDP, 8'h00},
        '{mk(6'b110101,1'b1,5'd1, 3'b000,7'b1010111), 2'b11, 64'h1111_1111_1111_1111, 64'h0, 32'h0, OLDP, 8'h00},
        '{mk(6'b110100,1'b1,5'd1, 3'b000,7'b1010111), 2'b00, 64'h1111_1111_1111_1111, 64'h0, 32'h0, OLDP, 8'h00}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [31:0]       instr = '0;
    logic [1:0]        sew_sel = '0;
    logic [VLEN-1:0]   vs2_data = '0;
    logic [VLEN-1:0]   vs1_data = '0;
    logic [31:0]       scalar_op = '0;
    logic [2*VLEN-1:0] old_dst = '0;
    logic [VLEN/8-1:0] elem_mask = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic              wr_en;
    logic              illegal;
    logic [2*VLEN-1:0] result;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    vwsll_unit #(.VLEN(VLEN)) u_vwsll_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .instr(instr), .sew_sel(sew_sel), .vs2_data(vs2_data), .vs1_data(vs1_data),
        .scalar_op(scalar_op), .old_dst(old_dst), .elem_mask(elem_mask),
        .out_valid(out_valid), .out_ready(out_ready), .wr_en(wr_en),
        .illegal(illegal), .result(result)
    );

    function automatic logic [128:0] model(input vec_t v);
        logic [2:0]   f3;
        logic         ok;
        int           sew;
        logic [127:0] res;
        f3 = v.ins[14:12];
        ok = (v.ins[31:26] == 6'b110101) && (v.ins[6:0] == 7'b1010111) &&
             (f3 == 3'b000 || f3 == 3'b100 || f3 == 3'b011) && (v.sew != 2'b11);
        if (!ok) return {1'b1, v.old};
        sew = 8 << v.sew;
        res = '0;
        for (int e = 0; e < 64 / sew; e++) begin
            logic [63:0]  lo;
            logic [127:0] lo2;
            logic [63:0]  s;
            logic [63:0]  a;
            logic [127:0] r;
            lo  = (64'd1 << sew) - 64'd1;
            lo2 = (128'd1 << (2 * sew)) - 128'd1;
            s   = (v.src >> (e * sew)) & lo;
            if (f3 == 3'b000)      a = (v.amt >> (e * sew)) & lo;
            else if (f3 == 3'b100) a = {32'd0, v.sc} & lo;
            else                   a = {59'd0, v.ins[19:15]};
            r = ({64'd0, s} << (a % (2 * sew))) & lo2;
            if (!v.ins[25] && !v.msk[e]) r = (v.old >> (e * 2 * sew)) & lo2;
            res = res | (r << (e * 2 * sew));
        end
        return {1'b0, res};
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        instr     = v.ins;
        sew_sel   = v.sew;
        vs2_data  = v.src;
        vs1_data  = v.amt;
        scalar_op = v.sc;
        old_dst   = v.old;
        elem_mask = v.msk;
    endtask

    task automatic run_op(input vec_t v);
        @(negedge clk);
        drive(v);
        in_valid  = 1'b1;
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        vec_t t;
        logic [128:0] m;
        logic [127:0] held;
        string tag;

        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9 out_valid", {127'd0, out_valid}, 128'd0);
        chk("R9 wr_en", {127'd0, wr_en}, 128'd0);
        chk("R9 result", result, 128'd0);
        chk("R9 in_ready", {127'd0, in_ready}, 128'd1);
        rst = 1'b0;

        foreach (TBL[k]) begin
            m = model(TBL[k]);
            if (m[128])                           tag = (TBL[k].sew == 2'b11) ? "R7" : "R1";
            else if (!TBL[k].ins[25])             tag = "R6";
            else if (TBL[k].ins[14:12] == 3'b000) tag = "R2";
            else if (TBL[k].ins[14:12] == 3'b100) tag = "R3";
            else                                  tag = "R4";
            run_op(TBL[k]);
            chk({tag, " result"}, result, m[127:0]);
            chk({tag, " illegal"}, {127'd0, illegal}, {127'd0, m[128]});
            chk({tag, " wr_en"}, {127'd0, wr_en}, {127'd0, ~m[128]});
            chk("R8 out_valid", {127'd0, out_valid}, 128'd1);
        end

        // R5: 0xFF << 15 at SEW=8 keeps only the top bit of the 16-bit lane
        t = '{mk(6'b110101,1'b1,5'd15,3'b011,7'b1010111), 2'b00, 64'h0000_0000_0000_00FF,
              64'h0, 32'h0, 128'h0, 8'h00};
        run_op(t);
        chk("R5 overflow drop", result, 128'h8000);

        // R8: stall holds result and blocks new requests
        t = '{mk(6'b110101,1'b1,5'd1,3'b011,7'b1010111), 2'b01, 64'h0000_0000_0000_0003,
              64'h0, 32'h0, 128'h0, 8'h00};
        @(negedge clk);
        drive(t);
        in_valid  = 1'b1;
        out_ready = 1'b0;
        @(negedge clk);
        held = result;
        chk("R8 stall result", held, 128'h6);
        chk("R8 in_ready low", {127'd0, in_ready}, 128'd0);
        t.ins = mk(6'b110101, 1'b1, 5'd4, 3'b011, 7'b1010111);
        drive(t);
        @(negedge clk);
        @(negedge clk);
        chk("R8 stall hold", result, 128'h6);
        chk("R8 stall valid", {127'd0, out_valid}, 128'd1);
        out_ready = 1'b1;
        #0;
        chk("R8 in_ready high", {127'd0, in_ready}, 128'd1);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 next result", result, 128'h30);
        @(negedge clk);
        chk("R8 drained", {127'd0, out_valid}, 128'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule